// File: doc/BRIEF.md
# Microsequencer Branch Resolution Unit

This unit owns the fetch program counter of a small command-processor microsequencer and decides, for each issued instruction, whether control flow changes. Decode hands it the opcode class, the value and index of the source register, a shared bit-number/immediate field, a signed displacement, an absolute call address and a few flag bits. The unit evaluates the condition, registers the taken decision and the destination, and moves the fetch PC.

Every redirect has one delay slot. The instruction that follows a taken branch, call or return is always executed, and only after it issues does the fetch PC move to the destination. Calls push a return address onto an eight-entry stack. Returns pop it. The secure-state switch instruction bypasses the delay-slot mechanism: on success it skips the next two instructions directly.

Top module: `mbr_unit`

## Requirements
- R1: While `rst_n` is low and after release, `fetch_pc` is RESET_PC (0), `br_taken`, `br_target`, `illegal`, `rs_ovf`, `rs_unf`, `irq_ret` and `secure_mode` are 0, and the return stack is empty.
- R2: An issued instruction that does not redirect advances `fetch_pc` by one on the next edge. With `issue` low, `fetch_pc` holds.
- R3: Opcode 1 is taken when the source differs from the zero-extended `fld`, and opcode 2 is taken when they are equal. The destination is `fetch_pc` plus `boff` read as signed, wrapping modulo 2^PC_W.
- R4: Opcodes 3 (bit set) and 4 (bit clear) test one condition. With `fld` of 0 the condition is that the whole source word is zero. With `fld` equal to N in 1..32 it is that bit N-1 is zero. For N above 32 the bit reads as zero. Opcode 4 is taken when the condition holds, and opcode 3 is taken when it does not.
- R5: A `src_sel` of 0 makes the source read as zero whatever `src_val` carries, so opcode 4 from it always jumps.
- R6: One cycle after a taken instruction issues, `br_taken` pulses high and `br_target` shows the destination, holding it until the next taken instruction. The next issued instruction runs at the following address, and `fetch_pc` becomes the destination after it issues.
- R7: Opcode 5 is always taken to the absolute `call_tgt` and pushes the call's address plus two. Opcode 6 is taken to the popped address. `irq_ret` pulses with it when `ret_irq` is set.
- R8: The stack holds 8 entries. A call on a full stack pulses `rs_ovf`, still jumps and drops the address. A return on an empty stack pulses `rs_unf` and is not taken.
- R9: Opcode 7 with `sec_ok` high loads `secure_mode` from `sec_bit` and sets `fetch_pc` to its own address plus 3. With `sec_ok` low, `secure_mode` is unchanged and the PC advances by one.
- R10: An opcode 1-6 issued with `rep`, or any opcode 1-7 issued in a delay slot, pulses `illegal` one cycle later and has no other effect than a plain instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction at `fetch_pc` issues this cycle |
| op | input | 3 | Opcode class: 0 other, 1 ne-imm, 2 eq-imm, 3 bit set, 4 bit clear, 5 call, 6 return, 7 secure switch |
| rep | input | 1 | Repeat modifier present |
| src_sel | input | 5 | Source register index (0 reads as zero) |
| src_val | input | 32 | Source register value |
| fld | input | 6 | Immediate or bit-number field |
| boff | input | 12 | Signed branch displacement |
| call_tgt | input | 12 | Absolute call address |
| ret_irq | input | 1 | Return is an interrupt return |
| sec_bit | input | 1 | Requested secure state (bit 0 of register 2) |
| sec_ok | input | 1 | Secure switch succeeds |
| fetch_pc | output | 12 | Address of the instruction to issue |
| br_taken | output | 1 | Registered taken pulse |
| br_target | output | 12 | Registered destination |
| illegal | output | 1 | Illegal control-transfer pulse |
| rs_ovf | output | 1 | Return-stack overflow pulse |
| rs_unf | output | 1 | Return-stack underflow pulse |
| irq_ret | output | 1 | Interrupt return taken pulse |
| secure_mode | output | 1 | Current secure state |

## Verification
The assertions check, on every cycle, the PC relations that follow from a single issue. These are holding while idle, moving to the stored destination after a delay slot, the plus-three skip, a call's absolute destination, the forced jump from register zero, and the mutual exclusion of the error pulses. Other behaviour depends on history and only the bench scenarios can expose it: the order of addresses popped from the stack, overflow and underflow at the exact depth, bit selection for each field value, and delay slots stretched by idle cycles. A behavioural model in the bench tracks all of this and is compared on every clock.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_BNEI  = 3'd1,
    OP_BEQI  = 3'd2,
    OP_BSET  = 3'd3,
    OP_BCLR  = 3'd4,
    OP_CALL  = 3'd5,
    OP_RET   = 3'd6,
    OP_SECSW = 3'd7
  } mbr_op_e;
endpackage

// File: rtl/mbr_cond.sv
module mbr_cond
  import mbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLD_W  = 6
) (
  input  mbr_op_e           op,
  input  logic [DATA_W-1:0] src,
  input  logic [FLD_W-1:0]  fld,
  output logic              hit
);
  localparam logic [FLD_W:0] BIT_LIM = (FLD_W+1)'(DATA_W);

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] shifted;
  logic [FLD_W-1:0]  bit_idx;
  logic              imm_eq;
  logic              bit_one;
  logic              cond_zero;

  always_comb begin
    imm_ext   = DATA_W'(fld);
    imm_eq    = (src == imm_ext);
    bit_idx   = fld - FLD_W'(1);
    shifted   = src >> bit_idx;
    bit_one   = (fld != '0) && ({1'b0, fld} <= BIT_LIM) && shifted[0];
    cond_zero = (fld == '0) ? (src == '0) : !bit_one;
    unique case (op)
      OP_BNEI: hit = !imm_eq;
      OP_BEQI: hit = imm_eq;
      OP_BSET: hit = !cond_zero;
      OP_BCLR: hit = cond_zero;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/mbr_retstack.sv
module mbr_retstack #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [PC_W-1:0] push_val,
  input  logic            pop,
  output logic [PC_W-1:0] top,
  output logic            full,
  output logic            empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] top_cnt;
  logic             do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CNT_MAX);
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    cnt_n   = cnt_q;
    if (do_push)     cnt_n = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_n = cnt_q - CNT_W'(1);
    top_cnt = cnt_q - CNT_W'(1);
    top     = mem[top_cnt[PTR_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (do_push || do_pop) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[cnt_q[PTR_W-1:0]] <= push_val;
  end
endmodule

// File: rtl/mbr_unit.sv
module mbr_unit
  import mbr_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int DATA_W    = 32,
  parameter int FLD_W     = 6,
  parameter int SEL_W     = 5,
  parameter int RS_DEPTH  = 8,
  parameter int RESET_PC  = 0,
  parameter int SEC_SKIP  = 3,
  parameter int CALL_LINK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [2:0]        op,
  input  logic              rep,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic [DATA_W-1:0] src_val,
  input  logic [FLD_W-1:0]  fld,
  input  logic [PC_W-1:0]   boff,
  input  logic [PC_W-1:0]   call_tgt,
  input  logic              ret_irq,
  input  logic              sec_bit,
  input  logic              sec_ok,
  output logic [PC_W-1:0]   fetch_pc,
  output logic              br_taken,
  output logic [PC_W-1:0]   br_target,
  output logic              illegal,
  output logic              rs_ovf,
  output logic              rs_unf,
  output logic              irq_ret,
  output logic              secure_mode
);
  localparam logic [PC_W-1:0] PC_RST  = PC_W'(RESET_PC);
  localparam logic [PC_W-1:0] PC_ONE  = PC_W'(1);
  localparam logic [PC_W-1:0] PC_SKIP = PC_W'(SEC_SKIP);
  localparam logic [PC_W-1:0] PC_LINK = PC_W'(CALL_LINK);

  mbr_op_e           op_e;
  logic [DATA_W-1:0] src_eff;
  logic              cond_hit;
  logic              is_br, is_ctl, is_xfer;
  logic              bad, act;
  logic              br_go, call_go, ret_go, ret_none, call_drop, sec_go;
  logic              take;
  logic [PC_W-1:0]   dest;
  logic [PC_W-1:0]   pc_n;
  logic [PC_W-1:0]   rs_top;
  logic              rs_full, rs_empty;

  logic [PC_W-1:0]   pc_q;
  logic              pend_q;
  logic              taken_q;
  logic [PC_W-1:0]   tgt_q;
  logic              ill_q, ovf_q, unf_q, irq_q, sec_q;

  mbr_cond #(.DATA_W(DATA_W), .FLD_W(FLD_W)) u_cond (
    .op  (op_e),
    .src (src_eff),
    .fld (fld),
    .hit (cond_hit)
  );

  mbr_retstack #(.DEPTH(RS_DEPTH), .PC_W(PC_W)) u_rs (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (call_go),
    .push_val (pc_q + PC_LINK),
    .pop      (ret_go),
    .top      (rs_top),
    .full     (rs_full),
    .empty    (rs_empty)
  );

  always_comb begin
    op_e      = mbr_op_e'(op);
    src_eff   = (src_sel == '0) ? '0 : src_val;
    is_br     = (op_e == OP_BNEI) || (op_e == OP_BEQI) ||
                (op_e == OP_BSET) || (op_e == OP_BCLR);
    is_ctl    = is_br || (op_e == OP_CALL) || (op_e == OP_RET);
    is_xfer   = is_ctl || (op_e == OP_SECSW);
    bad       = issue && ((rep && is_ctl) || (pend_q && is_xfer));
    act       = issue && !bad;
    br_go     = act && is_br && cond_hit;
    call_go   = act && (op_e == OP_CALL);
    call_drop = call_go && rs_full;
    ret_go    = act && (op_e == OP_RET) && !rs_empty;
    ret_none  = act && (op_e == OP_RET) && rs_empty;
    sec_go    = act && (op_e == OP_SECSW) && sec_ok;
    take      = br_go || call_go || ret_go;

    dest = tgt_q;
    if (br_go)        dest = pc_q + boff;
    else if (call_go) dest = call_tgt;
    else if (ret_go)  dest = rs_top;

    if (pend_q)      pc_n = tgt_q;
    else if (sec_go) pc_n = pc_q + PC_SKIP;
    else             pc_n = pc_q + PC_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= PC_RST;
      pend_q  <= 1'b0;
      taken_q <= 1'b0;
      tgt_q   <= '0;
      ill_q   <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      irq_q   <= 1'b0;
      sec_q   <= 1'b0;
    end else begin
      if (issue) begin
        pc_q   <= pc_n;
        pend_q <= take;
      end
      if (take)   tgt_q <= dest;
      if (sec_go) sec_q <= sec_bit;
      taken_q <= take;
      ill_q   <= bad;
      ovf_q   <= call_drop;
      unf_q   <= ret_none;
      irq_q   <= ret_go && ret_irq;
    end
  end

  assign fetch_pc    = pc_q;
  assign br_taken    = taken_q;
  assign br_target   = tgt_q;
  assign illegal     = ill_q;
  assign rs_ovf      = ovf_q;
  assign rs_unf      = unf_q;
  assign irq_ret     = irq_q;
  assign secure_mode = sec_q;
endmodule

// File: rtl/mbr_unit_chk.sv
module mbr_unit_chk #(
  parameter int PC_W  = 12,
  parameter int FLD_W = 6,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic [2:0]       op,
  input logic             rep,
  input logic [SEL_W-1:0] src_sel,
  input logic [PC_W-1:0]  call_tgt,
  input logic             sec_ok,
  input logic             pend_q,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             br_taken,
  input logic [PC_W-1:0]  br_target,
  input logic             illegal,
  input logic             rs_ovf,
  input logic             rs_unf
);
  a_r2_idle_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(fetch_pc));

  a_r6_slot_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && pend_q) |=> (fetch_pc == $past(br_target)));

  a_r6_taken_leaves_pending: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> pend_q);

  a_r7_call_absolute: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 3'd5 && !rep && !pend_q) |=> (br_taken && br_target == $past(call_tgt)));

  a_r9_secure_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 3'd7 && sec_ok && !pend_q) |=> (fetch_pc == PC_W'($past(fetch_pc) + PC_W'(3))));

  a_r5_zero_reg_jumps: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 3'd4 && src_sel == '0 && !rep && !pend_q) |=> br_taken);

  a_r10_illegal_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !br_taken);

  a_r8_error_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rs_ovf, rs_unf, illegal}));
endmodule

bind mbr_unit mbr_unit_chk #(.PC_W(PC_W), .FLD_W(FLD_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue     (issue),
  .op        (op),
  .rep       (rep),
  .src_sel   (src_sel),
  .call_tgt  (call_tgt),
  .sec_ok    (sec_ok),
  .pend_q    (pend_q),
  .fetch_pc  (fetch_pc),
  .br_taken  (br_taken),
  .br_target (br_target),
  .illegal   (illegal),
  .rs_ovf    (rs_ovf),
  .rs_unf    (rs_unf)
);

// File: tb/tb_mbr_unit.sv
`timescale 1ns/1ps
module tb_mbr_unit;
  logic        clk, rst_n;
  logic        issue, rep, ret_irq, sec_bit, sec_ok;
  logic [2:0]  op;
  logic [4:0]  src_sel;
  logic [31:0] src_val;
  logic [5:0]  fld;
  logic [11:0] boff, call_tgt;
  logic [11:0] fetch_pc, br_target;
  logic        br_taken, illegal, rs_ovf, rs_unf, irq_ret, secure_mode;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  logic [11:0] m_pc, m_tgt;
  logic        m_pend, m_taken, m_ill, m_ovf, m_unf, m_irq, m_sec;
  logic [11:0] stk[$];

  mbr_unit dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .rep(rep),
    .src_sel(src_sel), .src_val(src_val), .fld(fld), .boff(boff),
    .call_tgt(call_tgt), .ret_irq(ret_irq), .sec_bit(sec_bit), .sec_ok(sec_ok),
    .fetch_pc(fetch_pc), .br_taken(br_taken), .br_target(br_target),
    .illegal(illegal), .rs_ovf(rs_ovf), .rs_unf(rs_unf), .irq_ret(irq_ret),
    .secure_mode(secure_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("fetch_pc", 32'(fetch_pc), 32'(m_pc));
    check("br_taken", 32'(br_taken), 32'(m_taken));
    check("br_target", 32'(br_target), 32'(m_tgt));
    check("illegal", 32'(illegal), 32'(m_ill));
    check("rs_ovf", 32'(rs_ovf), 32'(m_ovf));
    check("rs_unf", 32'(rs_unf), 32'(m_unf));
    check("irq_ret", 32'(irq_ret), 32'(m_irq));
    check("secure_mode", 32'(secure_mode), 32'(m_sec));
  endtask

  task automatic cyc(input logic i_iss, input logic [2:0] i_op, input logic i_rep,
                     input logic [4:0] i_sel, input logic [31:0] i_val, input logic [5:0] i_fld,
                     input logic [11:0] i_off, input logic [11:0] i_ctgt, input logic i_irq,
                     input logic i_sbit, input logic i_sok);
    logic [31:0] s;
    logic        is_ctl, ill, tk, zr, skip;
    logic [11:0] tg, npc;
    issue = i_iss; op = i_op; rep = i_rep; src_sel = i_sel; src_val = i_val;
    fld = i_fld; boff = i_off; call_tgt = i_ctgt; ret_irq = i_irq;
    sec_bit = i_sbit; sec_ok = i_sok;
    s = (i_sel == 0) ? 32'd0 : i_val;
    is_ctl = (i_op >= 1 && i_op <= 6);
    ill = i_iss && ((is_ctl && i_rep) || (m_pend && i_op != 0));
    tk = 0; tg = m_tgt; skip = 0;
    m_ovf = 0; m_unf = 0; m_irq = 0;
    if (i_iss && !ill) begin
      case (i_op)
        3'd1: begin tk = (s != 32'(i_fld)); tg = m_pc + i_off; end
        3'd2: begin tk = (s == 32'(i_fld)); tg = m_pc + i_off; end
        3'd3, 3'd4: begin
          if (i_fld == 0) zr = (s == 0);
          else if (i_fld > 32) zr = 1;
          else zr = (s[i_fld-1] == 1'b0);
          tk = (i_op == 3'd4) ? zr : !zr;
          tg = m_pc + i_off;
        end
        3'd5: begin
          tk = 1; tg = i_ctgt;
          if (stk.size() == 8) m_ovf = 1;
          else stk.push_back(m_pc + 12'd2);
        end
        3'd6: begin
          if (stk.size() == 0) m_unf = 1;
          else begin tk = 1; tg = stk.pop_back(); m_irq = i_irq; end
        end
        3'd7: if (i_sok) begin m_sec = i_sbit; skip = 1; end
        default: ;
      endcase
    end
    if (!i_iss) npc = m_pc;
    else if (m_pend) npc = m_tgt;
    else if (skip) npc = m_pc + 12'd3;
    else npc = m_pc + 12'd1;
    m_pc = npc;
    if (i_iss) m_pend = tk;
    if (tk) m_tgt = tg;
    m_taken = tk;
    m_ill = ill;
    @(negedge clk);
    compare_all();
  endtask

  task automatic plain();
    cyc(1, 3'd0, 0, 5'd1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0;
    issue = 0; op = 0; rep = 0; src_sel = 0; src_val = 0; fld = 0;
    boff = 0; call_tgt = 0; ret_irq = 0; sec_bit = 0; sec_ok = 0;
    m_pc = 0; m_tgt = 0; m_pend = 0; m_taken = 0; m_ill = 0;
    m_ovf = 0; m_unf = 0; m_irq = 0; m_sec = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1"; compare_all();
    rst_n = 1;
    @(negedge clk); compare_all();

    cur_req = "R2";
    plain(); plain();
    cyc(0, 3'd1, 0, 5'd1, 1, 0, 12'd5, 0, 0, 0, 0);
    plain();

    cur_req = "R3";
    cyc(1, 3'd1, 0, 5'd2, 32'd7, 6'd7, 12'd20, 0, 0, 0, 0);
    cyc(1, 3'd1, 0, 5'd2, 32'd8, 6'd7, 12'hFFC, 0, 0, 0, 0);
    plain(); plain();
    cyc(1, 3'd2, 0, 5'd2, 32'd9, 6'd9, 12'hFF0, 0, 0, 0, 0);
    plain(); plain();
    cyc(1, 3'd2, 0, 5'd2, 32'h100, 6'd0, 12'd3, 0, 0, 0, 0);

    cur_req = "R4";
    cyc(1, 3'd4, 0, 5'd3, 32'd0, 6'd0, 12'd10, 0, 0, 0, 0); plain(); plain();
    cyc(1, 3'd4, 0, 5'd3, 32'h80, 6'd0, 12'd10, 0, 0, 0, 0); plain();
    cyc(1, 3'd3, 0, 5'd3, 32'h10, 6'd5, 12'd6, 0, 0, 0, 0); plain(); plain();
    cyc(1, 3'd4, 0, 5'd3, 32'h10, 6'd5, 12'd6, 0, 0, 0, 0); plain();
    cyc(1, 3'd3, 0, 5'd3, 32'h8000_0000, 6'd32, 12'd4, 0, 0, 0, 0); plain(); plain();
    cyc(1, 3'd3, 0, 5'd3, 32'hFFFF_FFFF, 6'd40, 12'd4, 0, 0, 0, 0); plain();
    cyc(1, 3'd4, 0, 5'd3, 32'hFFFF_FFFF, 6'd40, 12'd4, 0, 0, 0, 0); plain(); plain();

    cur_req = "R5";
    cyc(1, 3'd4, 0, 5'd0, 32'hDEAD_BEEF, 6'd1, 12'd30, 0, 0, 0, 0); plain(); plain();
    cyc(1, 3'd1, 0, 5'd0, 32'h5, 6'd5, 12'd30, 0, 0, 0, 0); plain();

    cur_req = "R6";
    cyc(1, 3'd2, 0, 5'd4, 32'd3, 6'd3, 12'd50, 0, 0, 0, 0);
    cyc(0, 3'd0, 0, 5'd0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 3'd0, 0, 5'd0, 0, 0, 0, 0, 0, 0, 0);
    plain(); plain();

    cur_req = "R7";
    cyc(1, 3'd5, 0, 5'd0, 0, 0, 0, 12'h300, 0, 0, 0); plain();
    cyc(1, 3'd5, 0, 5'd0, 0, 0, 0, 12'h400, 0, 0, 0); plain(); plain();
    cyc(1, 3'd6, 0, 5'd0, 0, 0, 0, 0, 1, 0, 0); plain(); plain();
    cyc(1, 3'd6, 0, 5'd0, 0, 0, 0, 0, 0, 0, 0); plain(); plain();

    cur_req = "R8";
    for (int k = 0; k < 9; k++) begin
      cyc(1, 3'd5, 0, 5'd0, 0, 0, 0, 12'(16 * k + 32), 0, 0, 0); plain();
    end
    for (int k = 0; k < 10; k++) begin
      cyc(1, 3'd6, 0, 5'd0, 0, 0, 0, 0, k[0], 0, 0); plain();
    end

    cur_req = "R9";
    cyc(1, 3'd7, 0, 5'd2, 0, 0, 0, 0, 0, 1, 1); plain();
    cyc(1, 3'd7, 0, 5'd2, 0, 0, 0, 0, 0, 0, 0); plain();
    cyc(1, 3'd7, 1, 5'd2, 0, 0, 0, 0, 0, 0, 1); plain();

    cur_req = "R10";
    cyc(1, 3'd4, 1, 5'd0, 0, 0, 12'd9, 0, 0, 0, 0); plain();
    cyc(1, 3'd5, 1, 5'd0, 0, 0, 0, 12'h111, 0, 0, 0); plain();
    cyc(1, 3'd4, 0, 5'd0, 0, 0, 12'd40, 0, 0, 0, 0);
    cyc(1, 3'd4, 0, 5'd0, 0, 0, 12'd80, 0, 0, 0, 0);
    plain();
    cyc(1, 3'd5, 0, 5'd0, 0, 0, 0, 12'h222, 0, 0, 0);
    cyc(1, 3'd7, 0, 5'd0, 0, 0, 0, 0, 0, 1, 1);
    plain();

    cur_req = "R6";
    for (int k = 0; k < 600; k++) begin
      cyc(($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)),
          ($urandom_range(0, 9) == 0), 5'($urandom_range(0, 3)),
          32'($urandom_range(0, 15)) << $urandom_range(0, 31), 6'($urandom_range(0, 40)),
          12'($urandom), 12'($urandom), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule